// File: doc/BRIEF.md
# Five-Stage Pipelined Register-to-Register Datapath

This block executes a straight-line stream of three-register arithmetic and logic instructions. It uses a five-stage pipeline: fetch, decode with operand read, execute, a memory stage that passes values through, and write-back. A new instruction enters on every clock, so up to five instructions are in flight at once. There are no stalls. Each pipeline register carries a valid flag and the instruction fields that later stages still need. Every stage decodes its own controls from those fields; no central controller exists.

The instruction store lies outside the block. The block presents a byte address and expects the 32-bit word at that address on the same cycle. A register observation port returns the contents of any architectural register one clock after the index is presented. Reset seeds every register with its own index, which gives programs distinct starting operands.

When one instruction depends on the result of an earlier one, the result is forwarded from the two later pipeline registers into the execute stage. A result three instructions back arrives through a write-through path in the register file.

Top module: `rpipe_core`

## Requirements
- R1: While reset is high and on the first cycle after it, `imem_addr` is 0 and `obs_data` is 0. After reset, register i holds the value i and register 0 holds 0.
- R2: Outside reset, `imem_addr` increases by 4 on every clock.
- R3: An instruction word has these fields: opcode [31:26], first source [25:21], second source [20:16], destination [15:11], shift amount [10:6] and function [5:0]. With opcode 0, the function codes are 0x20 add, 0x22 subtract (first minus second), 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A signed set-less-than (result 1 or 0), 0x00 shift the second source left by the shift amount, and 0x02 shift the second source right logically by the shift amount.
- R4: A word with a nonzero opcode, or with a function code not listed in R3, writes no register. No later instruction receives a forwarded value from it.
- R5: The result of the instruction fetched from address 4k is in the register file after clock edge k+5, counted from reset release.
- R6: An instruction that reads the destination of the instruction one or two places ahead of it uses that instruction's result.
- R7: An instruction that reads the destination of the instruction three places ahead of it uses that instruction's result.
- R8: When both in-flight producers write the same register, the consumer takes the value from the nearer (younger) one.
- R9: Register 0 always reads 0. It is never written and is never a forwarding source.
- R10: `obs_data` shows the register selected by `obs_addr` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Byte address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| obs_addr | input | $clog2(NREG) | Register index to observe |
| obs_data | output | XLEN | Registered contents of the observed register |

## Verification
The bench builds the core with its default 32-bit data path, 32 registers and a 32-bit program counter. With these defaults, subtraction wraps below zero, set-less-than compares negative against positive, and shift amounts reach 31, so sign and wrap cases are covered. Because 32 registers are seeded with distinct values, a single program can exercise forwarding at distances of one, two and three instructions, the nearest-producer priority, suppressed writes and register 0 all together. A reference interpreter in the bench then predicts every final register value.

// File: rtl/rpipe_pkg.sv
package rpipe_pkg;

  localparam int FLD_W = 5;

  typedef struct packed {
    logic [5:0]       opc;
    logic [FLD_W-1:0] rs;
    logic [FLD_W-1:0] rt;
    logic [FLD_W-1:0] rd;
    logic [FLD_W-1:0] sh;
    logic [5:0]       fn;
  } rinstr_t;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLL, OP_SRL, OP_NONE
  } alu_op_e;

  function automatic alu_op_e decode_alu(input logic [5:0] opc, input logic [5:0] fn);
    alu_op_e op;
    op = OP_NONE;
    if (opc == 6'd0) begin
      case (fn)
        6'h20:   op = OP_ADD;
        6'h22:   op = OP_SUB;
        6'h24:   op = OP_AND;
        6'h25:   op = OP_OR;
        6'h26:   op = OP_XOR;
        6'h27:   op = OP_NOR;
        6'h2A:   op = OP_SLT;
        6'h00:   op = OP_SLL;
        6'h02:   op = OP_SRL;
        default: op = OP_NONE;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/rpipe_fetch.sv
module rpipe_fetch #(
  parameter int PC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rpipe_pkg::rinstr_t   instr_in,
  output logic [PC_W-1:0]      pc_o,
  output logic                 ifid_v,
  output rpipe_pkg::rinstr_t   ifid_ins
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o     <= '0;
      ifid_v   <= 1'b0;
      ifid_ins <= '0;
    end else begin
      pc_o     <= pc_o + STEP;
      ifid_v   <= 1'b1;
      ifid_ins <= instr_in;
    end
  end
endmodule

// File: rtl/rpipe_regfile.sv
module rpipe_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   oa,
  output logic [XLEN-1:0] od
);
  logic [XLEN-1:0] mem [NREG];
  logic            wr_ok;

  assign wr_ok = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= XLEN'(i);
      od <= '0;
    end else begin
      if (wr_ok) mem[wa] <= wd;
      od <= mem[oa];
    end
  end

  // write-through so a read in the write-back cycle sees the new value
  assign rd_a = (wr_ok && wa == ra_a) ? wd : mem[ra_a];
  assign rd_b = (wr_ok && wa == ra_b) ? wd : mem[ra_b];
endmodule

// File: rtl/rpipe_alu.sv
module rpipe_alu #(
  parameter int XLEN = 32
) (
  input  rpipe_pkg::alu_op_e           op,
  input  logic [XLEN-1:0]              a,
  input  logic [XLEN-1:0]              b,
  input  logic [rpipe_pkg::FLD_W-1:0]  sh,
  output logic [XLEN-1:0]              y
);
  import rpipe_pkg::*;

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      OP_SLT:  y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      OP_SLL:  y = b << sh;
      OP_SRL:  y = b >> sh;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rpipe_fwd.sv
module rpipe_fwd #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [AW-1:0]   src,
  input  logic [XLEN-1:0] base,
  input  logic            near_v,
  input  logic            near_wen,
  input  logic [AW-1:0]   near_rd,
  input  logic [XLEN-1:0] near_val,
  input  logic            far_v,
  input  logic            far_wen,
  input  logic [AW-1:0]   far_rd,
  input  logic [XLEN-1:0] far_val,
  output logic [XLEN-1:0] opnd
);
  logic near_hit, far_hit;

  assign near_hit = near_v && near_wen && (near_rd == src) && (src != '0);
  assign far_hit  = far_v  && far_wen  && (far_rd  == src) && (src != '0);

  always_comb begin
    if (near_hit)     opnd = near_val;
    else if (far_hit) opnd = far_val;
    else              opnd = base;
  end
endmodule

// File: rtl/rpipe_core.sv
module rpipe_core #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int PC_W = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  input  logic [AW-1:0]   obs_addr,
  output logic [XLEN-1:0] obs_data
);
  import rpipe_pkg::*;

  // fetch stage and IF/ID
  logic    ifid_v;
  rinstr_t ifid_ins;

  rpipe_fetch #(.PC_W(PC_W)) u_fetch (
    .clk(clk), .rst(rst), .instr_in(rinstr_t'(imem_data)),
    .pc_o(imem_addr), .ifid_v(ifid_v), .ifid_ins(ifid_ins)
  );

  // write-back controls, decoded from MEM/WB contents
  logic            memwb_v, memwb_wen;
  logic [AW-1:0]   memwb_rd;
  logic [XLEN-1:0] memwb_res;
  logic            wb_we;

  assign wb_we = memwb_v && memwb_wen;

  // decode stage: operand read
  logic [XLEN-1:0] id_a, id_b;

  rpipe_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(ifid_ins.rs[AW-1:0]), .ra_b(ifid_ins.rt[AW-1:0]),
    .rd_a(id_a), .rd_b(id_b),
    .we(wb_we), .wa(memwb_rd), .wd(memwb_res),
    .oa(obs_addr), .od(obs_data)
  );

  // ID/EX
  logic            idex_v;
  rinstr_t         idex_ins;
  logic [XLEN-1:0] idex_a, idex_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      idex_v   <= 1'b0;
      idex_ins <= '0;
      idex_a   <= '0;
      idex_b   <= '0;
    end else begin
      idex_v   <= ifid_v;
      idex_ins <= ifid_ins;
      idex_a   <= id_a;
      idex_b   <= id_b;
    end
  end

  // EX/MEM
  logic            exmem_v, exmem_wen;
  logic [AW-1:0]   exmem_rd;
  logic [XLEN-1:0] exmem_res;

  // execute stage: local decode, forwarding, ALU
  alu_op_e         ex_op;
  logic            ex_wen;
  logic [AW-1:0]   ex_src  [2];
  logic [XLEN-1:0] ex_base [2];
  logic [XLEN-1:0] ex_opnd [2];
  logic [XLEN-1:0] ex_res;

  assign ex_op      = decode_alu(idex_ins.opc, idex_ins.fn);
  assign ex_wen     = idex_v && (ex_op != OP_NONE) && (idex_ins.rd[AW-1:0] != '0);
  assign ex_src[0]  = idex_ins.rs[AW-1:0];
  assign ex_src[1]  = idex_ins.rt[AW-1:0];
  assign ex_base[0] = idex_a;
  assign ex_base[1] = idex_b;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    rpipe_fwd #(.XLEN(XLEN), .AW(AW)) u_fwd (
      .src(ex_src[g]), .base(ex_base[g]),
      .near_v(exmem_v), .near_wen(exmem_wen), .near_rd(exmem_rd), .near_val(exmem_res),
      .far_v(memwb_v),  .far_wen(memwb_wen),  .far_rd(memwb_rd),  .far_val(memwb_res),
      .opnd(ex_opnd[g])
    );
  end

  rpipe_alu #(.XLEN(XLEN)) u_alu (
    .op(ex_op), .a(ex_opnd[0]), .b(ex_opnd[1]), .sh(idex_ins.sh), .y(ex_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exmem_v   <= 1'b0;
      exmem_wen <= 1'b0;
      exmem_rd  <= '0;
      exmem_res <= '0;
    end else begin
      exmem_v   <= idex_v;
      exmem_wen <= ex_wen;
      exmem_rd  <= idex_ins.rd[AW-1:0];
      exmem_res <= ex_res;
    end
  end

  // memory stage: pass-through into MEM/WB
  always_ff @(posedge clk) begin
    if (rst) begin
      memwb_v   <= 1'b0;
      memwb_wen <= 1'b0;
      memwb_rd  <= '0;
      memwb_res <= '0;
    end else begin
      memwb_v   <= exmem_v;
      memwb_wen <= exmem_wen;
      memwb_rd  <= exmem_rd;
      memwb_res <= exmem_res;
    end
  end
endmodule

// File: rtl/rpipe_core_chk.sv
module rpipe_core_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] imem_addr,
  input logic [AW-1:0]   obs_addr,
  input logic [XLEN-1:0] obs_data,
  input logic            exmem_v,
  input logic            exmem_wen,
  input logic            memwb_v,
  input logic            memwb_wen
);
  logic was_rst, armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_rst <= 1'b1;
      armed   <= 1'b0;
    end else begin
      was_rst <= 1'b0;
      armed   <= 1'b1;
    end
  end

  p_pc_reset_r1: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> imem_addr == '0);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> imem_addr == $past(imem_addr) + PC_W'(4));

  p_exmem_wen_valid_r4: assert property (@(posedge clk) disable iff (rst)
    exmem_wen |-> exmem_v);

  p_memwb_wen_valid_r4: assert property (@(posedge clk) disable iff (rst)
    memwb_wen |-> memwb_v);

  p_stage_flow_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && memwb_v) |-> $past(exmem_v));

  p_reg0_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (obs_addr == '0) |=> (obs_data == '0));
endmodule

bind rpipe_core rpipe_core_chk #(.XLEN(XLEN), .AW(AW), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .obs_addr(obs_addr),
  .obs_data(obs_data), .exmem_v(exmem_v), .exmem_wen(exmem_wen),
  .memwb_v(memwb_v), .memwb_wen(memwb_wen)
);

// File: tb/rpipe_core_test.sv
`timescale 1ns/1ps
module rpipe_core_test;

  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int PC_W = 32;
  localparam int AW   = $clog2(NREG);
  localparam int MEMW = 64;

  function automatic logic [31:0] enc(input logic [5:0] fn, input int rd, input int rs,
                                      input int rt, input int sh);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  localparam int NPROG = 20;
  localparam logic [31:0] MAIN_PROG [NPROG] = '{
    enc(6'h20,  8,  9, 10, 0),   // add  r8 = r9 + r10
    enc(6'h22,  4,  8,  3, 0),   // sub  r4 = r8 - r3   (distance 1)
    enc(6'h24,  9,  8,  4, 0),   // and  r9 = r8 & r4   (distance 2 and 1)
    enc(6'h25, 11,  8,  5, 0),   // or   r11 = r8 | r5  (distance 3)
    enc(6'h26, 12,  4,  9, 0),   // xor
    enc(6'h27, 13,  0,  1, 0),   // nor
    enc(6'h2A, 14, 13,  2, 0),   // slt negative < positive
    enc(6'h2A, 15,  2, 13, 0),   // slt positive < negative
    enc(6'h00, 16,  0, 13, 4),   // sll by 4
    enc(6'h02, 17,  0, 16, 28),  // srl by 28
    enc(6'h22, 18,  0, 31, 0),   // sub wraps below zero
    enc(6'h20,  0,  1,  2, 0),   // add into r0 (discarded)
    enc(6'h20, 19,  0,  0, 0),   // add r19 = r0 + r0
    enc(6'h20, 20,  1,  2, 0),
    enc(6'h20, 20, 20, 20, 0),   // second producer of r20
    enc(6'h20, 21, 20,  1, 0),   // nearest producer wins
    {6'h23, 5'd1, 5'd2, 5'd22, 5'd0, 6'h20},  // nonzero opcode
    enc(6'h3F, 23,  1,  2, 0),   // unlisted function code
    enc(6'h20, 24, 23, 22, 0),   // reads both unwritten targets
    enc(6'h00, 25,  0, 31, 31)   // sll by 31
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] imem_addr;
  logic [31:0]     imem_data;
  logic [AW-1:0]   obs_addr = '0;
  logic [XLEN-1:0] obs_data;
  logic [31:0]     prog [MEMW];
  logic [31:0]     exp_rf [NREG];
  int              n_tests = 0;
  int              n_fail  = 0;
  bit              done    = 1'b0;

  always #10 clk = ~clk;

  assign imem_data = (imem_addr[PC_W-1:2] < MEMW) ? prog[imem_addr[7:2]] : 32'h0;

  rpipe_core #(.XLEN(XLEN), .NREG(NREG), .PC_W(PC_W)) uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .obs_addr(obs_addr), .obs_data(obs_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < MEMW; i++) prog[i] = 32'h0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_reg(input int idx, output logic [31:0] val);
    @(negedge clk);
    obs_addr = AW'(idx);
    @(negedge clk);
    val = obs_data;
  endtask

  // sequential reference interpreter of the instruction set
  task automatic run_model();
    for (int i = 0; i < NREG; i++) exp_rf[i] = 32'(i);
    for (int k = 0; k < NPROG; k++) begin
      logic [31:0] w, a, b, y;
      bit ok;
      w  = MAIN_PROG[k];
      a  = exp_rf[w[25:21]];
      b  = exp_rf[w[20:16]];
      ok = (w[31:26] == 6'd0);
      y  = 32'h0;
      case (w[5:0])
        6'h20: y = a + b;
        6'h22: y = a - b;
        6'h24: y = a & b;
        6'h25: y = a | b;
        6'h26: y = a ^ b;
        6'h27: y = ~(a | b);
        6'h2A: y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h00: y = b << w[10:6];
        6'h02: y = b >> w[10:6];
        default: ok = 1'b0;
      endcase
      if (ok && w[15:11] != 5'd0) exp_rf[w[15:11]] = y;
    end
  endtask

  function automatic string tag_of(input int r);
    case (r)
      4, 8, 9:    return "R6 forward distance 1/2";
      11:         return "R7 write-through distance 3";
      0, 19:      return "R9 register 0";
      20, 21:     return "R8 nearest producer";
      22, 23, 24: return "R4 no write";
      default:    return "R3 operation";
    endcase
  endfunction

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    clear_prog();

    // R1: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", imem_addr, 32'h0);
    chk("R1 obs in reset", obs_data, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pc first cycle after reset", imem_addr, 32'h4);
    for (int r = 0; r < NREG; r++) begin
      read_reg(r, v);
      chk("R1 seeded register", v, 32'(r));
    end

    // R5, R2, R10: single instruction, cycle-exact
    clear_prog();
    prog[0] = enc(6'h20, 5, 1, 2, 0);
    obs_addr = AW'(5);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R2 pc step", imem_addr, 32'(4 * k));
      if (k <= 5) chk("R5 old value before write", obs_data, 32'd5);
      else        chk("R5 R10 written value visible", obs_data, 32'd3);
    end

    // R3, R4, R6, R7, R8, R9: full program against the interpreter
    clear_prog();
    for (int k = 0; k < NPROG; k++) prog[k] = MAIN_PROG[k];
    run_model();
    do_reset();
    repeat (NPROG + 10) @(negedge clk);
    for (int r = 0; r < NREG; r++) begin
      read_reg(r, v);
      chk(tag_of(r), v, exp_rf[r]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule